// File: doc/BRIEF.md
# Line-Rate Serial Port Sampler

This block watches two slow serial inputs, a keyboard-style PS/2 port (clock and data) and an RS-232 receive line, and advances a small state machine for each of them once per video scan line. The scan-line strobe arrives at roughly 38.4 kHz. That is fast enough to follow a PS/2 clock of up to 16.7 kHz and to oversample a 9600 baud RS-232 stream by about four. Both machines live in one 8-bit state word. The low nibble belongs to the PS/2 port and the high nibble to the RS-232 port. Each nibble holds a 2-bit state and a 2-bit data field.

The PS/2 half counts changes of the clock level, modulo four. On every high-to-low clock change it shifts the data pin into a 2-bit shift register. A separate process-cycle strobe records the PS/2 state and clock level at the start of a cycle. From that record and the live state, the block reports how many bits (0, 1 or 2) have arrived since the strobe. The RS-232 half restarts its phase count whenever RX changes. It takes a sample when the count reaches two, which falls about mid-bit. Each sample is flagged with a one-clock valid pulse.

A serial mode input selects which single interface is served. The PS/2 clock-inhibit output holds the keyboard off unless PS/2 is selected. RTS is asserted only while RS-232 is selected. Sampling itself runs in every mode. Grouping bits into bytes is left to the consumer.

Top module: `line_serial_sampler`

## Requirements
- R1: After reset, port_state reads 8'h20 (PS/2 state 0, PS/2 data 00, RS-232 state 0, RS-232 previous-RX bit 1, RS-232 sample 0), and rx_valid and ps2_new_bits read 0.
- R2: PS/2 state (port_state[3:2]) advances by one, modulo 4, on a line tick where the synchronised PS/2 clock differs from its level at the previous tick. It is otherwise unchanged, and unchanged on any clock without a line tick.
- R3: On a line tick where the PS/2 clock goes from 1 to 0, the PS/2 data field (port_state[1:0], also on ps2_bits) becomes {old bit 0, PS/2 data pin}. On any other tick it holds.
- R4: ps2_new_bits equals, with d = (current PS/2 state - start state) mod 4: (d+1)/2 if the start clock level was 1, else d/2 (integer division).
- R5: A cycle_strobe records the current PS/2 state and clock level as the start values. Directly after it, with no tick in between, ps2_new_bits reads 0.
- R6: On a line tick where RX differs from the previous-RX bit (port_state[5]), the RS-232 state (port_state[7:6]) becomes 0. On every tick, the previous-RX bit takes the new RX value.
- R7: On a line tick with no RX change, the RS-232 state advances by one and saturates at 3.
- R8: When a tick moves the RS-232 state from 1 to 2, the sample bit (port_state[4], also on rx_bit) takes RX, and rx_valid is 1 for exactly the following clock.
- R9: Mode encoding is 0 none, 1 PS/2, 2 RS-232, 3 none. ps2_clk_hold is 1 unless the mode is 1, and rts is 1 only when the mode is 2. Both follow mode within the same clock.
- R10: Both state machines keep sampling and advancing whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-clock pulse per scan line; advances both machines |
| cycle_strobe | input | 1 | One-clock pulse at a process-cycle boundary; records PS/2 start values |
| mode | input | 2 | Serial mode: 0 none, 1 PS/2, 2 RS-232 |
| ps2_clk_raw | input | 1 | Asynchronous PS/2 clock pin |
| ps2_dat_raw | input | 1 | Asynchronous PS/2 data pin |
| rx_raw | input | 1 | Asynchronous RS-232 receive line |
| ps2_clk_hold | output | 1 | Pulls the PS/2 clock low to inhibit the device |
| rts | output | 1 | Ready-to-send to the RS-232 peer |
| ps2_bits | output | 2 | PS/2 2-bit shift register |
| ps2_new_bits | output | 2 | PS/2 bits received since the last cycle_strobe |
| rx_valid | output | 1 | One-clock pulse when a new RS-232 sample is taken |
| rx_bit | output | 1 | Latest RS-232 mid-bit sample |
| port_state | output | 8 | Packed state word: [7:4] RS-232 nibble, [3:0] PS/2 nibble |

## Verification
The assertions take it for granted that line_tick pulses last one clock and are spaced by more than one clock. A new sample can then never follow directly on another. They also take it for granted that the raw pins have already crossed the synchroniser before a tick reads them. The stimulus changes a pin, then waits several clocks before the tick, so the value the bench model applies is the value the design sees. The bit-count rule can tell at most three PS/2 clock changes apart within one process cycle. The stimulus therefore caps the changes between strobes at three, which is what a 16.7 kHz clock allows over four lines.

// File: rtl/lss_pkg.sv
package lss_pkg;

    localparam int ST_W  = 2;
    localparam int DAT_W = 2;
    localparam int NIB_W = ST_W + DAT_W;

    localparam logic [ST_W-1:0] RX_SAMPLE_ST = 2'd2;
    localparam logic [ST_W-1:0] RX_SAT_ST    = 2'd3;

    typedef struct packed {
        logic [ST_W-1:0]  st;
        logic [DAT_W-1:0] dat;
    } nib_t;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_KBD  = 2'd1,
        MODE_UART = 2'd2,
        MODE_RSVD = 2'd3
    } smode_t;

    // PS/2 nibble: st counts clock level changes, dat shifts on falling edges
    function automatic nib_t kb_step(nib_t cur, logic lvl_prev, logic lvl_now, logic dat_now);
        nib_t n;
        n = cur;
        if (lvl_now != lvl_prev)
            n.st = cur.st + 1'b1;
        if (lvl_prev && !lvl_now)
            n.dat = {cur.dat[0], dat_now};
        return n;
    endfunction

    // Falling edges seen since the cycle start, from the change count and start level
    function automatic logic [1:0] kb_bits_since(logic [ST_W-1:0] st_start, logic lvl_start,
                                                 logic [ST_W-1:0] st_now);
        logic [ST_W-1:0] d;
        logic [ST_W:0]   sum;
        d   = st_now - st_start;
        sum = {1'b0, d} + {{ST_W{1'b0}}, lvl_start};
        return sum[ST_W:1];
    endfunction

    // RS-232 nibble: dat[1] is previous RX, dat[0] is the mid-bit sample
    function automatic nib_t rx_step(nib_t cur, logic rx_now);
        nib_t n;
        n = cur;
        if (rx_now != cur.dat[1])
            n.st = '0;
        else if (cur.st != RX_SAT_ST)
            n.st = cur.st + 1'b1;
        if (n.st == RX_SAMPLE_ST && cur.st != RX_SAMPLE_ST)
            n.dat[0] = rx_now;
        n.dat[1] = rx_now;
        return n;
    endfunction

endpackage

// File: rtl/lss_sync.sv
module lss_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lss_kb_tracker.sv
module lss_kb_tracker
    import lss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       strobe,
    input  logic       kclk,
    input  logic       kdat,
    output nib_t       nib,
    output logic [1:0] new_bits
);
    logic            lvl_prev;
    logic [ST_W-1:0] st_start;
    logic            lvl_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            nib      <= '0;
            lvl_prev <= 1'b1;
        end else if (tick) begin
            nib      <= kb_step(nib, lvl_prev, kclk, kdat);
            lvl_prev <= kclk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_start  <= '0;
            lvl_start <= 1'b1;
        end else if (strobe) begin
            st_start  <= nib.st;
            lvl_start <= lvl_prev;
        end
    end

    assign new_bits = kb_bits_since(st_start, lvl_start, nib.st);

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(nib));

    // R3
    rise_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && kclk) |=> $stable(nib.dat));
endmodule

// File: rtl/lss_rx_tracker.sv
module lss_rx_tracker
    import lss_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx,
    output nib_t nib,
    output logic valid
);
    nib_t nxt;

    always_comb nxt = rx_step(nib, rx);

    always_ff @(posedge clk) begin
        if (rst) begin
            nib   <= '{st: '0, dat: 2'b10};
            valid <= 1'b0;
        end else begin
            valid <= tick && (nxt.st == RX_SAMPLE_ST) && (nib.st != RX_SAMPLE_ST);
            if (tick)
                nib <= nxt;
        end
    end

    // R6
    edge_realign_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (rx != nib.dat[1])) |=> (nib.st == '0));

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (nib.st == RX_SAT_ST) |=> (nib.st == RX_SAT_ST || nib.st == '0));

    // R8
    valid_at_two_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (nib.st == RX_SAMPLE_ST));

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
endmodule

// File: rtl/line_serial_sampler.sv
module line_serial_sampler
    import lss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_tick,
    input  logic       cycle_strobe,
    input  logic [1:0] mode,
    input  logic       ps2_clk_raw,
    input  logic       ps2_dat_raw,
    input  logic       rx_raw,
    output logic       ps2_clk_hold,
    output logic       rts,
    output logic [1:0] ps2_bits,
    output logic [1:0] ps2_new_bits,
    output logic       rx_valid,
    output logic       rx_bit,
    output logic [7:0] port_state
);
    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_s;
    nib_t             kb_nib;
    nib_t             rx_nib;
    smode_t           mode_e;

    lss_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL({PIN_N{1'b1}})) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({rx_raw, ps2_dat_raw, ps2_clk_raw}),
        .q   (pins_s)
    );

    lss_kb_tracker u_kb (
        .clk      (clk),
        .rst      (rst),
        .tick     (line_tick),
        .strobe   (cycle_strobe),
        .kclk     (pins_s[0]),
        .kdat     (pins_s[1]),
        .nib      (kb_nib),
        .new_bits (ps2_new_bits)
    );

    lss_rx_tracker u_rx (
        .clk   (clk),
        .rst   (rst),
        .tick  (line_tick),
        .rx    (pins_s[2]),
        .nib   (rx_nib),
        .valid (rx_valid)
    );

    assign mode_e       = smode_t'(mode);
    assign ps2_clk_hold = (mode_e != MODE_KBD);
    assign rts          = (mode_e == MODE_UART);

    assign ps2_bits   = kb_nib.dat;
    assign rx_bit     = rx_nib.dat[0];
    assign port_state = {rx_nib, kb_nib};

    // R9
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        rts |-> ps2_clk_hold);
endmodule

// File: tb/line_serial_sampler_bench.sv
module line_serial_sampler_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_tick = 1'b0;
    logic       cycle_strobe = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       ps2_clk_raw = 1'b1;
    logic       ps2_dat_raw = 1'b1;
    logic       rx_raw = 1'b1;
    logic       ps2_clk_hold, rts, rx_valid, rx_bit;
    logic [1:0] ps2_bits, ps2_new_bits;
    logic [7:0] port_state;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model
    int ks = 0, kd = 0, kprev = 1, s0 = 0, l0 = 1;
    int rs = 0, rprev = 1, rsamp = 0, exp_valid = 0;

    always #4 clk = ~clk;

    line_serial_sampler u_line_serial_sampler (
        .clk(clk), .rst(rst), .line_tick(line_tick), .cycle_strobe(cycle_strobe),
        .mode(mode), .ps2_clk_raw(ps2_clk_raw), .ps2_dat_raw(ps2_dat_raw), .rx_raw(rx_raw),
        .ps2_clk_hold(ps2_clk_hold), .rts(rts), .ps2_bits(ps2_bits),
        .ps2_new_bits(ps2_new_bits), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .port_state(port_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_count();
        int d;
        d = (ks - s0 + 4) % 4;
        return (l0 == 1) ? (d + 1) / 2 : d / 2;
    endfunction

    task automatic step();
        string tag;
        @(negedge clk);
        tag = (mode == 2'd1) ? "R2/R3" : "R2/R3/R10";
        chk({tag, " ps2 nibble"}, port_state[3:0], ks * 4 + kd);
        chk("R3 ps2_bits", ps2_bits, kd);
        chk((mode == 2'd2) ? "R6/R7/R8 rx nibble" : "R6/R7/R8/R10 rx nibble",
            port_state[7:4], rs * 4 + rprev * 2 + rsamp);
        chk("R4 ps2_new_bits", ps2_new_bits, exp_count());
        chk("R8 rx_valid", rx_valid, exp_valid);
        chk("R8 rx_bit", rx_bit, rsamp);
        chk("R9 ps2_clk_hold", ps2_clk_hold, (mode != 2'd1) ? 1 : 0);
        chk("R9 rts", rts, (mode == 2'd2) ? 1 : 0);
    endtask

    task automatic model_tick();
        int kc, kdt, rx;
        kc = ps2_clk_raw; kdt = ps2_dat_raw; rx = rx_raw;
        if (kc != kprev) ks = (ks + 1) % 4;
        if (kprev == 1 && kc == 0) kd = ((kd * 2) % 4) + kdt;
        kprev = kc;
        exp_valid = 0;
        if (rx != rprev) rs = 0;
        else begin
            if (rs == 1) begin
                exp_valid = 1;
                rsamp = rx;
            end
            if (rs < 3) rs++;
        end
        rprev = rx;
    endtask

    // pins were set by the caller at a falling edge; let them settle, then tick
    task automatic line();
        repeat (3) step();
        line_tick = 1'b1;
        model_tick();
        step();
        line_tick = 1'b0;
        exp_valid = 0;
    endtask

    task automatic strobe();
        cycle_strobe = 1'b1;
        s0 = ks;
        l0 = kprev;
        step();
        cycle_strobe = 1'b0;
        chk("R5 count after strobe", ps2_new_bits, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 reset state", port_state, 8'h20);
        chk("R1 reset valid", rx_valid, 0);
        chk("R1 reset count", ps2_new_bits, 0);

        // R9 mode sweep
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0];
            step();
        end

        // PS/2 directed: start high, three changes -> 2 bits (R4)
        mode = 2'd1;
        strobe();
        ps2_dat_raw = 1'b1; ps2_clk_raw = 1'b0; line();
        ps2_clk_raw = 1'b1; line();
        ps2_dat_raw = 1'b0; ps2_clk_raw = 1'b0; line();
        line();
        chk("R4 three changes from high", ps2_new_bits, 2);
        // start low, three changes -> 1 bit
        strobe();
        ps2_clk_raw = 1'b1; line();
        ps2_dat_raw = 1'b1; ps2_clk_raw = 1'b0; line();
        ps2_clk_raw = 1'b1; line();
        line();
        chk("R4 three changes from low", ps2_new_bits, 1);

        // PS/2 random process cycles, at most three changes each
        for (int c = 0; c < 80; c++) begin
            int n;
            n = 0;
            strobe();
            for (int l = 0; l < 4; l++) begin
                @(negedge clk);
                ps2_dat_raw = $urandom_range(0, 1);
                if (n < 3 && $urandom_range(0, 2) != 0) begin
                    ps2_clk_raw = ~ps2_clk_raw;
                    n++;
                end
                line();
            end
        end
        @(negedge clk);
        ps2_clk_raw = 1'b1;
        line();

        // RS-232: bit stream with drifting bit lengths (R6, R7, R8)
        mode = 2'd2;
        for (int b = 0; b < 150; b++) begin
            int len;
            len = $urandom_range(3, 6);
            @(negedge clk);
            rx_raw = $urandom_range(0, 1);
            for (int l = 0; l < len; l++) line();
        end
        // one-line glitch restarts phase
        @(negedge clk); rx_raw = 1'b1; line(); line(); line();
        @(negedge clk); rx_raw = 1'b0; line();
        @(negedge clk); rx_raw = 1'b1; line();
        chk("R6 glitch realign", port_state[7:6], 0);
        line(); line(); line(); line();
        chk("R7 saturate", port_state[7:6], 3);

        // mode 0 / 3: both machines keep running (R10)
        for (int c = 0; c < 60; c++) begin
            int n;
            n = 0;
            mode = (c % 2 == 0) ? 2'd0 : 2'd3;
            strobe();
            for (int l = 0; l < 4; l++) begin
                @(negedge clk);
                ps2_dat_raw = $urandom_range(0, 1);
                rx_raw = $urandom_range(0, 3) == 0 ? ~rx_raw : rx_raw;
                if (n < 3 && $urandom_range(0, 1) != 0) begin
                    ps2_clk_raw = ~ps2_clk_raw;
                    n++;
                end
                line();
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule